// File: doc/BRIEF.md
# Paired-Byte Clock-Crossing Receive Queue

This block takes a fast byte stream that is clocked by its own source clock, unrelated to the system clock, and lands it in a small circular queue that a consumer on the system clock empties whenever it is ready. Bytes are combined two at a time into 16-bit words before anything crosses between clocks. As a result, the queue sees one write for every two byte strobes, which lets the storage side run at half the arrival rate.

The write and read positions are kept as binary counters in their own clock domains. Each position is sent to the other domain as a Gray-coded value through a two-stage synchronizer. The consumer sees a show-ahead word together with an empty indication, and asserts a read strobe to move on to the next word.

If a finished word arrives while the queue is full, the word is discarded and the entries already stored are left intact. A sticky overflow flag is raised in the source domain and stays set until a clear strobe in that same domain removes it.

Top module: `byte_pair_queue`

## Requirements
- R1: While reset is held and after it is released, `empty` is 1 and `ovf_flag` is 0.
- R2: The first byte of a pair occupies bits [7:0] of the stored word and the second byte occupies bits [15:8].
- R3: A lone unpaired byte is held inside the block and produces no word; the queue stays empty until the partner byte arrives, at which point exactly one word becomes readable.
- R4: Words are read out in the order in which they were completed. `rd_data` shows the oldest unread word whenever `empty` is 0.
- R5: `empty` is 1 exactly when every completed word has been read. A read strobe given while `empty` is 1 is ignored and does not move the read position.
- R6: A word completed while the queue already holds 16 words is dropped and `ovf_flag` is set. The 16 stored words remain intact. The 16th word on its own does not set the flag.
- R7: `ovf_flag` is sticky: it stays at 1 until `ovf_clr` is sampled high on `src_clk`. If a drop and a clear happen on the same edge, the drop wins and the flag stays set.
- R8: The queue wraps around its 16 entries indefinitely without losing or reordering words, and each synchronized pointer changes by at most one Gray bit per clock.
- R9: Source cycles in which `byte_valid` is 0 add no data, whatever value `byte_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Byte source clock |
| src_rst | input | 1 | Synchronous active-high reset, source domain |
| byte_in | input | 8 | Incoming byte |
| byte_valid | input | 1 | Qualifies `byte_in` on this source cycle |
| ovf_clr | input | 1 | Clears the sticky overflow flag (source domain) |
| ovf_flag | output | 1 | Sticky overflow flag (source domain) |
| sys_clk | input | 1 | System clock for the consumer |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| rd_en | input | 1 | Consumes the word shown on `rd_data` |
| rd_data | output | 16 | Oldest unread word (show-ahead) |
| empty | output | 1 | High when no unread word is available |

## Verification
Two events can land on the same source-clock edge: a word being dropped because the queue is full, and a clear of the overflow flag. The bench fills the queue to 16 words and sends one more pair. It then raises `ovf_clr` on exactly the cycle in which the completed word reaches the write controller, and checks that the flag is still set afterwards. A later standalone clear must bring the flag down. On the read side, reads issued while the queue is empty are overlapped with a word arriving afterwards, and the bench checks that the read position did not slip.

// File: rtl/bpq_pkg.sv
package bpq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } word_t;

    function automatic word_t pair_bytes(input logic [BYTE_W-1:0] first,
                                         input logic [BYTE_W-1:0] second);
        word_t w;
        w.lo = first;
        w.hi = second;
        return w;
    endfunction

endpackage

// File: rtl/byte_pairer.sv
module byte_pairer
    import bpq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_valid,
    output word_t             word_out,
    output logic              word_valid
);
    logic              have_first;
    logic [BYTE_W-1:0] first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_first <= 1'b0;
            first_q    <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (byte_valid) begin
                if (have_first) begin
                    word_out   <= pair_bytes(first_q, byte_in);
                    word_valid <= 1'b1;
                    have_first <= 1'b0;
                end else begin
                    first_q    <= byte_in;
                    have_first <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ptr_sync.sv
module ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/queue_store.sv
module queue_store #(
    parameter int AW = 4,
    parameter int W  = 16
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/queue_wr_ctrl.sv
module queue_wr_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic [AW:0]   rd_gray_sync,
    input  logic          ovf_clr,
    output logic          wr_en,
    output logic          wr_full,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wr_gray,
    output logic          ovf_flag
);
    logic [AW:0] wr_bin;
    logic [AW:0] wr_bin_nx;
    logic [AW:0] full_pat;

    assign full_pat  = {~rd_gray_sync[AW:AW-1], rd_gray_sync[AW-2:0]};
    assign wr_full   = (wr_gray == full_pat);
    assign wr_en     = wr_req & ~wr_full;
    assign wr_bin_nx = wr_bin + 1'b1;
    assign waddr     = wr_bin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin   <= '0;
            wr_gray  <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_en) begin
                wr_bin  <= wr_bin_nx;
                wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
            end
            if (wr_req && wr_full) ovf_flag <= 1'b1;
            else if (ovf_clr)      ovf_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/queue_rd_ctrl.sv
module queue_rd_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wr_gray_sync,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rd_gray,
    output logic          empty
);
    logic [AW:0] rd_bin;
    logic [AW:0] rd_bin_nx;

    assign empty     = (rd_gray == wr_gray_sync);
    assign rd_bin_nx = rd_bin + 1'b1;
    assign raddr     = rd_bin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (rd_en && !empty) begin
            rd_bin  <= rd_bin_nx;
            rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
        end
    end
endmodule

// File: rtl/byte_pair_queue.sv
module byte_pair_queue
    import bpq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_valid,
    input  logic              ovf_clr,
    output logic              ovf_flag,
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty
);
    localparam int PW = AW + 1;

    word_t          pair_word;
    logic           wr_req;
    logic           wr_en;
    logic           wr_full;
    logic [AW-1:0]  waddr;
    logic [AW-1:0]  raddr;
    logic [PW-1:0]  wr_gray;
    logic [PW-1:0]  rd_gray;
    logic [PW-1:0]  wr_gray_sync;
    logic [PW-1:0]  rd_gray_sync;

    byte_pairer u_pair (
        .clk        (src_clk),
        .rst        (src_rst),
        .byte_in    (byte_in),
        .byte_valid (byte_valid),
        .word_out   (pair_word),
        .word_valid (wr_req)
    );

    queue_wr_ctrl #(.AW(AW)) u_wr (
        .clk          (src_clk),
        .rst          (src_rst),
        .wr_req       (wr_req),
        .rd_gray_sync (rd_gray_sync),
        .ovf_clr      (ovf_clr),
        .wr_en        (wr_en),
        .wr_full      (wr_full),
        .waddr        (waddr),
        .wr_gray      (wr_gray),
        .ovf_flag     (ovf_flag)
    );

    queue_store #(.AW(AW), .W(WORD_W)) u_store (
        .wclk  (src_clk),
        .we    (wr_en),
        .waddr (waddr),
        .wdata (pair_word),
        .raddr (raddr),
        .rdata (rd_data)
    );

    ptr_sync #(.W(PW)) u_w2r (
        .clk (sys_clk),
        .rst (sys_rst),
        .d   (wr_gray),
        .q   (wr_gray_sync)
    );

    ptr_sync #(.W(PW)) u_r2w (
        .clk (src_clk),
        .rst (src_rst),
        .d   (rd_gray),
        .q   (rd_gray_sync)
    );

    queue_rd_ctrl #(.AW(AW)) u_rd (
        .clk          (sys_clk),
        .rst          (sys_rst),
        .rd_en        (rd_en),
        .wr_gray_sync (wr_gray_sync),
        .raddr        (raddr),
        .rd_gray      (rd_gray),
        .empty        (empty)
    );
endmodule

// File: rtl/bpq_checker.sv
module bpq_checker #(
    parameter int AW = 4
) (
    input logic          src_clk,
    input logic          src_rst,
    input logic          sys_clk,
    input logic          sys_rst,
    input logic          wr_req,
    input logic          wr_full,
    input logic [AW:0]   wr_gray,
    input logic          ovf_flag,
    input logic          ovf_clr,
    input logic          empty,
    input logic [AW-1:0] raddr
);
    // R6: a completed word meeting a full queue raises the flag
    a_r6_drop_sets_flag: assert property (@(posedge src_clk) disable iff (src_rst)
        (wr_req && wr_full) |=> ovf_flag);

    // R6: a dropped word leaves the write position where it was
    a_r6_drop_keeps_ptr: assert property (@(posedge src_clk) disable iff (src_rst)
        (wr_req && wr_full) |=> $stable(wr_gray));

    // R7: the flag holds until a clear arrives
    a_r7_sticky: assert property (@(posedge src_clk) disable iff (src_rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R7: a clear with no coincident drop lowers the flag
    a_r7_clear: assert property (@(posedge src_clk) disable iff (src_rst)
        (ovf_clr && !(wr_req && wr_full)) |=> !ovf_flag);

    // R5: reads while empty leave the read position unchanged
    a_r5_hold_when_empty: assert property (@(posedge sys_clk) disable iff (sys_rst)
        empty |=> $stable(raddr));

    // R8: the crossing pointer moves by at most one Gray bit per clock
    a_r8_gray_step: assert property (@(posedge src_clk) disable iff (src_rst)
        $onehot0(wr_gray ^ $past(wr_gray)));
endmodule

bind byte_pair_queue bpq_checker #(.AW(AW)) u_chk (
    .src_clk  (src_clk),
    .src_rst  (src_rst),
    .sys_clk  (sys_clk),
    .sys_rst  (sys_rst),
    .wr_req   (wr_req),
    .wr_full  (wr_full),
    .wr_gray  (wr_gray),
    .ovf_flag (ovf_flag),
    .ovf_clr  (ovf_clr),
    .empty    (empty),
    .raddr    (raddr)
);

// File: tb/tb_byte_pair_queue.sv
module tb_byte_pair_queue;
    logic        src_clk = 1'b0;
    logic        sys_clk = 1'b0;
    logic        src_rst = 1'b1;
    logic        sys_rst = 1'b1;
    logic [7:0]  byte_in = '0;
    logic        byte_valid = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        ovf_flag;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        empty;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [$];

    always #4   src_clk = ~src_clk;   // 125 MHz byte source
    always #2.5 sys_clk = ~sys_clk;   // 200 MHz system

    byte_pair_queue dut (
        .src_clk    (src_clk),
        .src_rst    (src_rst),
        .byte_in    (byte_in),
        .byte_valid (byte_valid),
        .ovf_clr    (ovf_clr),
        .ovf_flag   (ovf_flag),
        .sys_clk    (sys_clk),
        .sys_rst    (sys_rst),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .empty      (empty)
    );

    function automatic logic [15:0] expect_word(input logic [7:0] first,
                                                input logic [7:0] second);
        return {second, first};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge src_clk);
        byte_in    = b;
        byte_valid = 1'b1;
    endtask

    task automatic src_gap();
        @(negedge src_clk);
        byte_valid = 1'b0;
        byte_in    = 8'($urandom);
    endtask

    task automatic settle();
        repeat (14) @(negedge sys_clk);
    endtask

    task automatic send_word(input logic [7:0] a, input logic [7:0] b);
        send_byte(a);
        send_byte(b);
    endtask

    task automatic read_word(input logic [15:0] exp, input string tag);
        @(negedge sys_clk);
        chk(!empty, tag, 32'(empty), 32'd0);
        chk(rd_data == exp, tag, 32'(rd_data), 32'(exp));
        rd_en = 1'b1;
        @(negedge sys_clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] ov_lo(input int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [7:0] ov_hi(input int i);
        return 8'(8'hC0 + i);
    endfunction

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge src_clk);
        src_rst = 1'b0;
        @(negedge sys_clk);
        sys_rst = 1'b0;
        settle();

        // R1 reset state
        chk(empty == 1'b1, "R1 empty after reset", 32'(empty), 32'd1);
        chk(ovf_flag == 1'b0, "R1 ovf after reset", 32'(ovf_flag), 32'd0);

        // R3 lone byte held, then R2 packing order
        send_byte(8'h11);
        src_gap();
        settle();
        chk(empty == 1'b1, "R3 lone byte held", 32'(empty), 32'd1);
        send_byte(8'h22);
        src_gap();
        settle();
        read_word(expect_word(8'h11, 8'h22), "R2 R3 pair order");
        settle();
        chk(empty == 1'b1, "R5 empty after drain", 32'(empty), 32'd1);

        // R5 reads while empty are ignored
        @(negedge sys_clk);
        rd_en = 1'b1;
        repeat (3) @(negedge sys_clk);
        rd_en = 1'b0;
        send_word(8'hB2, 8'hA1);
        src_gap();
        settle();
        read_word(16'hA1B2, "R5 read ignored when empty");
        settle();
        chk(empty == 1'b1, "R5 empty again", 32'(empty), 32'd1);

        // R9 gaps with junk do not add data
        send_byte(8'h5A);
        src_gap();
        src_gap();
        src_gap();
        send_byte(8'hC3);
        src_gap();
        src_gap();
        settle();
        read_word(expect_word(8'h5A, 8'hC3), "R9 gap ignored");
        settle();
        chk(empty == 1'b1, "R9 no extra word", 32'(empty), 32'd1);

        // R6 overflow: sixteen fit, seventeenth dropped
        for (int i = 0; i < 16; i++) send_word(ov_lo(i), ov_hi(i));
        src_gap();
        settle();
        chk(ovf_flag == 1'b0, "R6 sixteen words no overflow", 32'(ovf_flag), 32'd0);
        send_word(8'hEE, 8'hFF);
        src_gap();
        settle();
        chk(ovf_flag == 1'b1, "R6 overflow raised", 32'(ovf_flag), 32'd1);
        for (int i = 0; i < 16; i++)
            read_word(expect_word(ov_lo(i), ov_hi(i)), "R6 contents preserved");
        settle();
        chk(empty == 1'b1, "R6 dropped word absent", 32'(empty), 32'd1);

        // R7 sticky, clear, and drop-beats-clear
        chk(ovf_flag == 1'b1, "R7 flag sticky after drain", 32'(ovf_flag), 32'd1);
        @(negedge src_clk);
        ovf_clr = 1'b1;
        @(negedge src_clk);
        ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R7 flag cleared", 32'(ovf_flag), 32'd0);
        for (int i = 0; i < 16; i++) send_word(ov_lo(i + 20), ov_hi(i + 20));
        src_gap();
        settle();
        send_word(8'h01, 8'h02);
        @(negedge src_clk);
        byte_valid = 1'b0;
        ovf_clr    = 1'b1;
        @(negedge src_clk);
        ovf_clr    = 1'b0;
        chk(ovf_flag == 1'b1, "R7 drop wins over clear", 32'(ovf_flag), 32'd1);
        @(negedge src_clk);
        ovf_clr = 1'b1;
        @(negedge src_clk);
        ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R7 later clear", 32'(ovf_flag), 32'd0);
        for (int i = 0; i < 16; i++)
            read_word(expect_word(ov_lo(i + 20), ov_hi(i + 20)), "R6 R7 contents");
        settle();
        chk(empty == 1'b1, "R5 empty after refill drain", 32'(empty), 32'd1);

        // R4 R8 random bursts wrapping the queue
        for (int r = 0; r < 24; r++) begin
            int n;
            n = 1 + int'($urandom % 12);
            for (int k = 0; k < n; k++) begin
                logic [7:0] a;
                logic [7:0] b;
                a = 8'($urandom);
                b = 8'($urandom);
                send_byte(a);
                if ($urandom % 3 == 0) src_gap();
                send_byte(b);
                model.push_back(expect_word(a, b));
            end
            src_gap();
            settle();
            while (model.size() > 0) read_word(model.pop_front(), "R4 R8 order and wrap");
            settle();
            chk(empty == 1'b1, "R5 R8 empty after burst", 32'(empty), 32'd1);
        end
        chk(ovf_flag == 1'b0, "R6 no overflow in bursts", 32'(ovf_flag), 32'd0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule